// File: doc/BRIEF.md
# Word Memory Access Unit

This block is the data-memory stage of a small 32-bit core that only moves whole words. Each cycle it may receive a load or a store request. The request carries a base register value, a 12-bit signed offset, the word to store and the index of the destination register. The block adds the base and the sign-extended offset to form the byte address. It then checks that the address is word aligned and that its word index falls inside the implemented memory. A single-port word memory, modelled inside the block, receives only the accesses that pass both checks.

A rejected access never reaches the memory. In the same cycle as the request, the block raises an error flag and drives a fixed bad-data-address code. A legal load returns its word one cycle after the request, together with a register write strobe and the destination index. The core can write these straight into its register file. Misaligned or out-of-range accesses are never split or emulated: either check failing is a hard error.

Top module: `wordmem_access_unit`

## Requirements
- R1: The byte address is base_i plus ofs_i sign-extended to 32 bits, computed modulo 2^32 (wrap-around is not an error), and the accessed word is that address shifted right by two.
- R2: A request whose byte address has a nonzero value in bits [1:0] is rejected: err_o is high in the same cycle as the request.
- R3: A request whose word index (address bits [31:2]) is greater than or equal to DEPTH is rejected: err_o is high in the same cycle as the request; index DEPTH-1 is legal.
- R4: While err_o is high, err_code_o equals 4'h1 (bad data address) for both rejection causes; otherwise err_code_o is 4'h0, and with no request strobe asserted err_o is low.
- R5: A legal store (st_i high) writes wdata_i into the addressed word, which a later legal load of that word returns.
- R6: A legal load (ld_i high, st_i low) makes rf_we_o high for exactly the next cycle, with rf_waddr_o equal to the rd_i of the request and rf_wdata_o equal to the addressed word.
- R7: A rejected store leaves every memory word unchanged.
- R8: A rejected load produces no rf_we_o pulse in the following cycle.
- R9: When ld_i and st_i are both high, only the store is performed (address checks apply to it), and no rf_we_o pulse follows.
- R10: During reset and in the first cycle after it, rf_we_o is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ld_i | input | 1 | Load request strobe |
| st_i | input | 1 | Store request strobe |
| base_i | input | XLEN | Base register value |
| ofs_i | input | IMM_W | Signed offset immediate |
| wdata_i | input | XLEN | Word to store |
| rd_i | input | RIDX_W | Destination register index of a load |
| err_o | output | 1 | Access rejected, same cycle as the request |
| err_code_o | output | CODE_W | Error code, 4'h1 on bad address, else 0 |
| rf_we_o | output | 1 | Register write strobe for returned load data |
| rf_waddr_o | output | RIDX_W | Destination index of returned load data |
| rf_wdata_o | output | XLEN | Returned load word |

## Verification
The bench builds the unit with DEPTH set to 16 words, so the top word (byte 0x3C) and the first illegal index (byte 0x40) are reachable with small bases and offsets. Negative offsets and a base near 2^32 exercise wrap-around of the address sum. With so few words, the bench can store to an address and later load from the same word through a different base and offset pair. It can also confirm that rejected stores left the top word and the reused words intact.

// File: rtl/wma_pkg.sv
package wma_pkg;
  localparam int XLEN   = 32;
  localparam int IMM_W  = 12;
  localparam int RIDX_W = 5;
  localparam int CODE_W = 4;

  localparam logic [CODE_W-1:0] CODE_NONE      = 4'h0;
  localparam logic [CODE_W-1:0] CODE_BAD_DADDR = 4'h1;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_STORE = 2'd2
  } op_e;
endpackage

// File: rtl/wma_addr_check.sv
module wma_addr_check
  import wma_pkg::*;
#(
  parameter int XW     = 32,
  parameter int IW     = 12,
  parameter int CW     = 4,
  parameter int DEPTH  = 1024,
  localparam int IDX_W = XW - 2,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          ld_i,
  input  logic          st_i,
  input  logic [XW-1:0] base_i,
  input  logic [IW-1:0] ofs_i,
  output logic          err_o,
  output logic [CW-1:0] code_o,
  output logic          mem_we_o,
  output logic          mem_re_o,
  output logic [AW-1:0] mem_addr_o
);
  logic [XW-1:0]    ea;
  logic [IDX_W-1:0] word_idx;
  logic             aligned;
  logic             in_range;
  logic             legal;
  op_e              op;

  always_comb begin
    if (st_i)      op = OP_STORE;
    else if (ld_i) op = OP_LOAD;
    else           op = OP_IDLE;
  end

  assign ea       = base_i + {{(XW-IW){ofs_i[IW-1]}}, ofs_i};
  assign word_idx = ea[XW-1:2];
  assign aligned  = (ea[1:0] == 2'b00);
  assign in_range = (word_idx < IDX_W'(DEPTH));
  assign legal    = (op != OP_IDLE) && aligned && in_range;

  assign err_o      = (op != OP_IDLE) && !legal;
  assign code_o     = err_o ? CW'(CODE_BAD_DADDR) : CW'(CODE_NONE);
  assign mem_we_o   = legal && (op == OP_STORE);
  assign mem_re_o   = legal && (op == OP_LOAD);
  assign mem_addr_o = word_idx[AW-1:0];
endmodule

// File: rtl/wma_word_ram.sv
module wma_word_ram #(
  parameter int DW    = 32,
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[addr_i] <= wdata_i;
    if (re_i) rdata_o <= mem[addr_i];
  end
endmodule

// File: rtl/wma_load_ret.sv
module wma_load_ret #(
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fire_i,
  input  logic [RW-1:0] rd_i,
  output logic          we_o,
  output logic [RW-1:0] waddr_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      we_o    <= 1'b0;
      waddr_o <= '0;
    end else begin
      we_o <= fire_i;
      if (fire_i) waddr_o <= rd_i;
    end
  end
endmodule

// File: rtl/wordmem_access_unit.sv
module wordmem_access_unit
  import wma_pkg::*;
#(
  parameter int XLEN_P = wma_pkg::XLEN,
  parameter int IMM_P  = wma_pkg::IMM_W,
  parameter int RIDX_P = wma_pkg::RIDX_W,
  parameter int CODE_P = wma_pkg::CODE_W,
  parameter int DEPTH  = 1024,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_i,
  input  logic              st_i,
  input  logic [XLEN_P-1:0] base_i,
  input  logic [IMM_P-1:0]  ofs_i,
  input  logic [XLEN_P-1:0] wdata_i,
  input  logic [RIDX_P-1:0] rd_i,
  output logic              err_o,
  output logic [CODE_P-1:0] err_code_o,
  output logic              rf_we_o,
  output logic [RIDX_P-1:0] rf_waddr_o,
  output logic [XLEN_P-1:0] rf_wdata_o
);
  logic          mem_we;
  logic          mem_re;
  logic [AW-1:0] mem_addr;

  wma_addr_check #(
    .XW(XLEN_P), .IW(IMM_P), .CW(CODE_P), .DEPTH(DEPTH)
  ) u_check (
    .ld_i(ld_i), .st_i(st_i), .base_i(base_i), .ofs_i(ofs_i),
    .err_o(err_o), .code_o(err_code_o),
    .mem_we_o(mem_we), .mem_re_o(mem_re), .mem_addr_o(mem_addr)
  );

  wma_word_ram #(.DW(XLEN_P), .DEPTH(DEPTH)) u_ram (
    .clk(clk), .we_i(mem_we), .re_i(mem_re), .addr_i(mem_addr),
    .wdata_i(wdata_i), .rdata_o(rf_wdata_o)
  );

  wma_load_ret #(.RW(RIDX_P)) u_ret (
    .clk(clk), .rst(rst), .fire_i(mem_re), .rd_i(rd_i),
    .we_o(rf_we_o), .waddr_o(rf_waddr_o)
  );
endmodule

// File: rtl/wma_checker.sv
module wma_checker #(
  parameter int XW    = 32,
  parameter int IW    = 12,
  parameter int RW    = 5,
  parameter int CW    = 4,
  parameter int DEPTH = 1024
) (
  input logic          clk,
  input logic          rst,
  input logic          ld_i,
  input logic          st_i,
  input logic [XW-1:0] base_i,
  input logic [IW-1:0] ofs_i,
  input logic          err_o,
  input logic [CW-1:0] err_code_o,
  input logic          rf_we_o,
  input logic [RW-1:0] rf_waddr_o,
  input logic [RW-1:0] rd_i
);
  logic [XW-1:0] ea_ref;
  logic          req;
  assign ea_ref = base_i + {{(XW-IW){ofs_i[IW-1]}}, ofs_i};
  assign req    = ld_i || st_i;

  a_r2_unaligned_rejected: assert property (@(posedge clk) disable iff (rst)
    (req && ea_ref[1:0] != 2'b00) |-> err_o);

  a_r3_out_of_range_rejected: assert property (@(posedge clk) disable iff (rst)
    (req && ({2'b00, ea_ref[XW-1:2]} >= XW'(DEPTH))) |-> err_o);

  a_r4_code_on_error: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (err_code_o == CW'(1)));

  a_r4_quiet_when_idle: assert property (@(posedge clk) disable iff (rst)
    !req |-> (!err_o && err_code_o == '0));

  a_r6_load_writeback: assert property (@(posedge clk) disable iff (rst)
    (ld_i && !st_i && !err_o) |=> (rf_we_o && rf_waddr_o == $past(rd_i)));

  a_r8_no_writeback_on_error: assert property (@(posedge clk) disable iff (rst)
    (ld_i && err_o) |=> !rf_we_o);

  a_r9_store_wins: assert property (@(posedge clk) disable iff (rst)
    (ld_i && st_i) |=> !rf_we_o);

  a_r10_reset_quiet: assert property (@(posedge clk)
    rst |=> !rf_we_o);
endmodule

bind wordmem_access_unit wma_checker #(
  .XW(XLEN_P), .IW(IMM_P), .RW(RIDX_P), .CW(CODE_P), .DEPTH(DEPTH)
) i_wma_checker (
  .clk(clk), .rst(rst), .ld_i(ld_i), .st_i(st_i), .base_i(base_i),
  .ofs_i(ofs_i), .err_o(err_o), .err_code_o(err_code_o),
  .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .rd_i(rd_i)
);

// File: tb/test_wordmem_access_unit.sv
module test_wordmem_access_unit;
  localparam int DEPTH = 16;
  localparam int NV    = 13;

  typedef struct packed {
    logic        ld;
    logic [31:0] base;
    logic [11:0] ofs;
    logic [31:0] wd;
    logic [4:0]  rd;
    logic        err;
    logic [31:0] rdata;
  } vec_t;

  // ld: 1 = load, 0 = store
  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'h0000_0020, 12'h004, 32'hA1A1_0009, 5'd0,  1'b0, 32'h0},          // R1 R5 word 9
    '{1'b0, 32'h0000_0040, 12'hFC0, 32'h1111_0000, 5'd0,  1'b0, 32'h0},          // R1 negative ofs -> word 0
    '{1'b0, 32'h0000_003C, 12'h000, 32'hFFFF_000F, 5'd0,  1'b0, 32'h0},          // R3 top word legal
    '{1'b0, 32'h0000_003C, 12'h004, 32'hDEAD_DEAD, 5'd0,  1'b1, 32'h0},          // R3 R7 index 16
    '{1'b0, 32'h0000_0021, 12'h003, 32'h2222_0009, 5'd0,  1'b0, 32'h0},          // R1 sum aligned
    '{1'b0, 32'h0000_0024, 12'h001, 32'hBAD0_BAD0, 5'd0,  1'b1, 32'h0},          // R2 R7 unaligned store
    '{1'b1, 32'h0000_0030, 12'hFF4, 32'h0,         5'd5,  1'b0, 32'h2222_0009},  // R6 R7
    '{1'b1, 32'h0000_0000, 12'h000, 32'h0,         5'd1,  1'b0, 32'h1111_0000},  // R6
    '{1'b1, 32'h0000_003C, 12'h000, 32'h0,         5'd31, 1'b0, 32'hFFFF_000F},  // R7 top intact
    '{1'b1, 32'h0000_003E, 12'h000, 32'h0,         5'd3,  1'b1, 32'h0},          // R2 R8
    '{1'b1, 32'hFFFF_FFF0, 12'h010, 32'h0,         5'd2,  1'b0, 32'h1111_0000},  // R1 wrap
    '{1'b1, 32'h8000_0000, 12'h000, 32'h0,         5'd4,  1'b1, 32'h0},          // R3 R8
    '{1'b1, 32'h0000_0000, 12'hFFC, 32'h0,         5'd6,  1'b1, 32'h0}           // R3 wrap below 0
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_i = 1'b0, st_i = 1'b0;
  logic [31:0] base_i = '0, wdata_i = '0;
  logic [11:0] ofs_i = '0;
  logic [4:0]  rd_i = '0;
  logic        err_o, rf_we_o;
  logic [3:0]  err_code_o;
  logic [4:0]  rf_waddr_o;
  logic [31:0] rf_wdata_o;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  wordmem_access_unit #(.DEPTH(DEPTH)) i_wordmem_access_unit (
    .clk(clk), .rst(rst), .ld_i(ld_i), .st_i(st_i), .base_i(base_i),
    .ofs_i(ofs_i), .wdata_i(wdata_i), .rd_i(rd_i), .err_o(err_o),
    .err_code_o(err_code_o), .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o),
    .rf_wdata_o(rf_wdata_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Inputs applied after a falling edge; err checked mid low phase,
  // write-back checked at the following falling edge.
  task automatic do_op(input logic ld, input logic st, input logic [31:0] b,
                       input logic [11:0] o, input logic [31:0] wd, input logic [4:0] rd,
                       input logic exp_err, input logic exp_we, input logic [31:0] exp_rd);
    ld_i = ld; st_i = st; base_i = b; ofs_i = o; wdata_i = wd; rd_i = rd;
    #1;
    check(exp_err ? "R2/R3 err" : "R4 no err", {31'b0, err_o}, {31'b0, exp_err});
    check("R4 code", {28'b0, err_code_o}, exp_err ? 32'h1 : 32'h0);
    @(negedge clk);
    ld_i = 1'b0; st_i = 1'b0;
    check(exp_we ? "R6 we" : "R8/R9 no we", {31'b0, rf_we_o}, {31'b0, exp_we});
    if (exp_we) begin
      check("R6 waddr", {27'b0, rf_waddr_o}, {27'b0, rd});
      check("R5/R6 data", rf_wdata_o, exp_rd);
    end
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 we in reset", {31'b0, rf_we_o}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R10 we after reset", {31'b0, rf_we_o}, 32'h0);
    check("R4 idle err", {31'b0, err_o}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      do_op(VECS[i].ld, !VECS[i].ld, VECS[i].base, VECS[i].ofs, VECS[i].wd,
            VECS[i].rd, VECS[i].err, VECS[i].ld && !VECS[i].err, VECS[i].rdata);
    end

    // R9: both strobes, store wins, no write-back
    do_op(1'b1, 1'b1, 32'h8, 12'h000, 32'h3333_0002, 5'd7, 1'b0, 1'b0, 32'h0);
    do_op(1'b1, 1'b0, 32'h4, 12'h004, 32'h0, 5'd8, 1'b0, 1'b1, 32'h3333_0002);
    // R9: both strobes with bad address rejects the store
    do_op(1'b1, 1'b1, 32'h9, 12'h000, 32'h4444_4444, 5'd9, 1'b1, 1'b0, 32'h0);
    do_op(1'b1, 1'b0, 32'h8, 12'h000, 32'h0, 5'd10, 1'b0, 1'b1, 32'h3333_0002);
    // R6: write strobe lasts one cycle only
    @(negedge clk);
    check("R6 single pulse", {31'b0, rf_we_o}, 32'h0);
    // R7: rejected store at index 16 did not alias to word 0
    do_op(1'b1, 1'b0, 32'h0, 12'h000, 32'h0, 5'd11, 1'b0, 1'b1, 32'h1111_0000);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule